// File: doc/BRIEF.md
# Pulse-Injection Phase-Adding Divider

This block is the digital core of the proportional path in a time-based PWM controller. It has two oscillator streams, A and B. Each arrives as a one-cycle strobe per oscillator edge. A primary counter divides each stream by 32 and gives a base signal and its complement.

Four secondary dividers repeat the same count. On top of the oscillator strobes they also count injected slip pulses. Each extra pulse brings a secondary output's rising edge forward by one oscillator period. Phase is added by moving edges earlier, not by delaying them, so no fixed centre delay enters the loop.

LEAD slips feed the stream A secondaries and LAG slips feed the stream B secondaries. With a 32 MHz oscillator, the divided outputs run at 1 MHz.

Everything is in one clock domain. All state is registered, so an input strobe sampled at a clock edge shows up on the outputs just after that edge.

Top module: `pulse_phase_divider`

## Requirements
- R1: Each primary output (`div_a`, `div_b`) changes level only on a clock edge that samples its oscillator strobe. It stays low for 16 strobes and high for the next 16 (period 32 strobes). The `_n` output is its inverse whenever the block is out of reset.
- R2: A secondary divider whose controlling primary level is high is held cleared. Its output equals that controlling level, which is high. The base secondary of a stream is controlled by the primary base output, and the complementary secondary by the primary complement.
- R3: A secondary divider whose controlling level is low counts oscillator strobes plus slip strobes from zero. Its output goes high on the edge where the total reaches 16, and never later than its controlling level rises.
- R4: Once a secondary output is high, it stays high until its controlling level falls. It falls on that same edge.
- R5: `lead` reaches only the stream A secondaries and `lag` reaches only the stream B secondaries. Slips on one stream never move the other stream's edges.
- R6: A slip reaches whichever secondary of its stream is counting at that moment. That is the base secondary while the primary base output is low, and the complementary secondary while it is high. Both half-periods can therefore be advanced.
- R7: With no slips, every secondary output equals its controlling primary output cycle for cycle, with a period of 32 strobes.
- R8: Each slip accepted before the count completes advances that secondary's rising edge by exactly one oscillator period. A slip that coincides with an oscillator strobe is counted as well, so the count increases by 2.
- R9: The secondary count saturates at 16. Excess slips only keep the output high.
- R10: Synchronous active-low reset clears all counters. All eight outputs are low on the edge after `rst_n` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_a | input | 1 | One-cycle strobe per stream A oscillator edge |
| osc_b | input | 1 | One-cycle strobe per stream B oscillator edge |
| lead | input | 1 | Slip strobe injected into stream A secondaries |
| lag | input | 1 | Slip strobe injected into stream B secondaries |
| div_a | output | 1 | Stream A primary divided base output |
| div_a_n | output | 1 | Stream A primary divided complement |
| div_b | output | 1 | Stream B primary divided base output |
| div_b_n | output | 1 | Stream B primary divided complement |
| adv_a | output | 1 | Advanced version of `div_a` |
| adv_a_n | output | 1 | Advanced version of `div_a_n` |
| adv_b | output | 1 | Advanced version of `div_b` |
| adv_b_n | output | 1 | Advanced version of `div_b_n` |

## Verification
The two streams are driven with strobes every four clocks, offset by one clock. Successive half-periods carry 0 to 3 slips, and the slip count differs between streams in the same window. This separates a correct one-period-per-slip advance from an off-by-one, and catches slips leaking into the wrong stream.

Alternate windows place the slips on the same cycle as an oscillator strobe, which exposes a divider that counts only one of the two. Slips arrive in both the low and the high half, so an allocation that advances only the base edge is caught.

A burst of slips on every cycle drives the counts into saturation. A mid-run reset then checks that all outputs clear and the divide sequence restarts from zero.

// File: rtl/pulse_phase_divider.sv
module pulse_phase_divider #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_a,
  input  logic osc_b,
  input  logic lead,
  input  logic lag,
  output logic div_a,
  output logic div_a_n,
  output logic div_b,
  output logic div_b_n,
  output logic adv_a,
  output logic adv_a_n,
  output logic adv_b,
  output logic adv_b_n
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);
  localparam int SW   = $clog2(HALF + 1);

  logic          live;
  logic [1:0]    osc, slip, phase, divv, divn;
  logic [3:0]    sctrl, sdone, advv;
  logic [CW-1:0] pcnt [2];
  logic [SW-1:0] scnt [4];

  assign osc  = {osc_b, osc_a};
  assign slip = {lag, lead};

  always_ff @(posedge clk) live <= rst_n;

  for (genvar s = 0; s < 2; s++) begin : g_stream
    always_ff @(posedge clk) begin
      if (!rst_n)      pcnt[s] <= '0;
      else if (osc[s]) pcnt[s] <= (pcnt[s] == CW'(DIV - 1)) ? '0 : pcnt[s] + CW'(1);
    end

    assign phase[s]       = pcnt[s] >= CW'(HALF);
    assign sctrl[2*s]     = phase[s];
    assign sctrl[2*s + 1] = ~phase[s];
    assign divv[s]        = live & phase[s];
    assign divn[s]        = live & ~phase[s];

    for (genvar h = 0; h < 2; h++) begin : g_sec
      localparam int I = 2 * s + h;
      logic [SW:0] sum, nxt;
      assign sum = {1'b0, scnt[I]} + (SW + 1)'(osc[s]) + (SW + 1)'(slip[s]);
      assign nxt = (sum >= (SW + 1)'(HALF)) ? (SW + 1)'(HALF) : sum;

      always_ff @(posedge clk) begin
        if (!rst_n || sctrl[I]) begin
          scnt[I]  <= '0;
          sdone[I] <= 1'b0;
        end else begin
          scnt[I]  <= nxt[SW-1:0];
          sdone[I] <= nxt == (SW + 1)'(HALF);
        end
      end

      assign advv[I] = live & (sdone[I] | sctrl[I]);

      AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        scnt[I] <= SW'(HALF)); // R9
    end

    AST_BASE_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(divv[s]) |-> advv[2*s]); // R3
    AST_COMP_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(divn[s]) |-> advv[2*s + 1]); // R6
    AST_BASE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(divv[s]) |-> !advv[2*s]); // R4
    AST_PRIM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(divv[s]) |-> $past(osc[s])); // R1
  end

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (divv == 2'b00 && divn == 2'b00 && advv == 4'b0000)); // R10

  assign div_a   = divv[0];
  assign div_a_n = divn[0];
  assign div_b   = divv[1];
  assign div_b_n = divn[1];
  assign adv_a   = advv[0];
  assign adv_a_n = advv[1];
  assign adv_b   = advv[2];
  assign adv_b_n = advv[3];
endmodule

// File: tb/pulse_phase_divider_tb.sv
`timescale 1ns/1ps
module pulse_phase_divider_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, osc_a, osc_b, lead, lag;
  logic div_a, div_a_n, div_b, div_b_n, adv_a, adv_a_n, adv_b, adv_b_n;
  logic [7:0] actv;

  pulse_phase_divider dut_i (
    .clk(clk), .rst_n(rst_n), .osc_a(osc_a), .osc_b(osc_b), .lead(lead), .lag(lag),
    .div_a(div_a), .div_a_n(div_a_n), .div_b(div_b), .div_b_n(div_b_n),
    .adv_a(adv_a), .adv_a_n(adv_a_n), .adv_b(adv_b), .adv_b_n(adv_b_n));

  // bit order: 0 div_a, 1 div_a_n, 2 div_b, 3 div_b_n, 4 adv_a, 5 adv_a_n, 6 adv_b, 7 adv_b_n
  assign actv = {adv_b_n, adv_b, adv_a_n, adv_a, div_b_n, div_b, div_a_n, div_a};

  int total = 0, bad = 0, cyc = 0;
  bit done_flag = 0, timing_on = 0, sat_on = 0;
  string tag = "R10";

  // behavioural reference
  int m_pc [2];
  int m_sc [4];
  bit m_dn [4];
  bit m_live = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_live = 0;
      for (int i = 0; i < 2; i++) m_pc[i] = 0;
      for (int i = 0; i < 4; i++) begin m_sc[i] = 0; m_dn[i] = 0; end
    end else begin
      m_live = 1;
      for (int s = 0; s < 2; s++) begin
        int p, sl;
        bit hi;
        p  = (s == 0) ? int'(osc_a) : int'(osc_b);
        sl = (s == 0) ? int'(lead)  : int'(lag);
        hi = m_pc[s] >= 16;
        for (int h = 0; h < 2; h++) begin
          int i;
          i = 2 * s + h;
          if ((h == 0) ? hi : !hi) begin
            m_sc[i] = 0; m_dn[i] = 0;
          end else begin
            m_sc[i] = m_sc[i] + p + sl;
            if (m_sc[i] > 16) m_sc[i] = 16;
            m_dn[i] = (m_sc[i] == 16);
          end
        end
        m_pc[s] = (m_pc[s] + p) % 32;
      end
    end
  end

  function automatic logic [7:0] expv();
    logic [7:0] e;
    for (int s = 0; s < 2; s++) begin
      bit hi;
      hi = m_pc[s] >= 16;
      e[2*s]     = m_live & hi;
      e[2*s + 1] = m_live & !hi;
      e[4 + 2*s]     = m_live & (m_dn[2*s] | hi);
      e[4 + 2*s + 1] = m_live & (m_dn[2*s + 1] | !hi);
    end
    return e;
  endfunction

  task automatic chk(string r, logic [7:0] a, logic [7:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%b exp=%b", r, cyc, a, e);
    end
  endtask

  task automatic chki(string r, int a, int e);
    total++;
    if (a != e) begin
      bad++;
      $display("FAIL %s cyc=%0d act=%0d exp=%0d", r, cyc, a, e);
    end
  endtask

  // edge-advance bookkeeping
  int win [2] = '{0, 0};
  int inj [2] = '{0, 0};
  int t_rise [4] = '{0, 0, 0, 0};
  logic [7:0] prev = '0;

  task automatic edge_track();
    for (int j = 0; j < 4; j++)
      if (actv[4 + j] && !prev[4 + j]) t_rise[j] = cyc;
    for (int s = 0; s < 2; s++) begin
      if (actv[2*s] && prev[2*s]) chk("R2 held", {7'd0, actv[4 + 2*s]}, 8'd1);
      if (actv[2*s] != prev[2*s]) begin
        if (actv[2*s]) begin
          chki(inj[s] == 0 ? "R7 base edge" : "R8 base advance", t_rise[2*s], cyc - 4 * inj[s]);
          chk("R4 comp fall", {7'd0, actv[5 + 2*s]}, 8'd0);
        end else begin
          chki("R6 comp advance", t_rise[2*s + 1], cyc - 4 * inj[s]);
          chk("R4 base fall", {7'd0, actv[4 + 2*s]}, 8'd0);
        end
        win[s]++;
        inj[s] = 0;
      end
    end
  endtask

  task automatic tick();
    bit ia, ib;
    int want_a, want_b, slot_a, slot_b;
    @(negedge clk);
    chk(tag, actv, expv());
    if (timing_on) edge_track();
    prev = actv;
    want_a = win[0] % 4;
    want_b = (win[1] + 1) % 4;         // R5: B schedule differs from A
    slot_a = (win[0] % 8 >= 4) ? 0 : 2; // coincident with osc_a in alternate windows
    slot_b = (win[1] % 8 >= 4) ? 1 : 3;
    ia = timing_on && inj[0] < want_a && (cyc % 4 == slot_a);
    ib = timing_on && inj[1] < want_b && (cyc % 4 == slot_b);
    if (ia) inj[0]++;
    if (ib) inj[1]++;
    osc_a = (cyc % 4 == 0);
    osc_b = (cyc % 4 == 1);
    lead  = ia | sat_on;
    lag   = ib | sat_on;
    cyc++;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    rst_n = 0; osc_a = 0; osc_b = 0; lead = 0; lag = 0;
    repeat (3) @(negedge clk);
    chk("R10 reset", actv, 8'h00);
    rst_n = 1;
    tag = "R1 R3 R5 timing";
    timing_on = 1;
    repeat (1200) tick();
    timing_on = 0;
    sat_on = 1;
    tag = "R9 saturate";
    repeat (200) tick();
    sat_on = 0;
    tag = "R7 plain";
    repeat (200) tick();
    rst_n = 0;
    tag = "R10 reset";
    repeat (3) tick();
    chk("R10 outputs low", actv, 8'h00);
    rst_n = 1;
    tag = "R1 R2 restart";
    repeat (300) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end
endmodule